// File: doc/BRIEF.md
# Return-from-exception frame format decoder

This block settles what a return-from-exception instruction does once the status word, the return PC and the format/vector word have been fetched from the supervisor stack. The frame format code, the number of stack bytes already consumed (the base offset), and a processor generation selector come in together with a one-cycle start pulse. One clock later the block reports exactly one outcome. It can finish, with a stack-pointer adjustment that depends on the format. It can ask for a further frame to be read, because the frame just consumed was a throwaway frame. Or it can reject the frame as a format error.

The accepted format codes and the extra bytes each one skips depend on the generation. Generation encoding on `gen_i`: 0 = base (no format word), 1 = second, 2 = third/fourth, 3 = fifth. A flag marks the memory-management variant of the third/fourth generation, which accepts one more long frame. The restored status word is handed back for commit only on a successful finish. Fetching memory and any MMU-specific restart work are left to the surrounding sequencer.

Top module: `rte_frame_decoder`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `done_o`, `reread_o`, `fmt_err_o`, `sr_we_o`, `sp_delta_o` and `err_vec_o` are all zero.
- R2: One cycle after a cycle with `start_i` high, exactly one of `done_o`, `reread_o`, `fmt_err_o` is high. One cycle after a cycle with `start_i` low, all three are low and `sp_delta_o` is zero.
- R3: Format code 0x0 is accepted on generations 1, 2 and 3; it finishes with `sp_delta_o` equal to the base offset.
- R4: Format code 0x8 is accepted only on generation 1 and finishes with `sp_delta_o` = base offset + 50.
- R5: Format codes 0x1 and 0x2 are accepted only on generations 2 and 3. Code 0x2 finishes with base offset + 4. Code 0x1 raises `reread_o` (not `done_o`) with `sp_delta_o` equal to the base offset.
- R6: Format codes 0x3, 0x4 and 0x7 are accepted only on generation 3 and finish with base offset + 4, + 8 and + 52 respectively.
- R7: Format code 0x9 is accepted only on generation 2 and finishes with base offset + 12. Format code 0xB is accepted only on generation 2 with `mmu_var_i` high, and finishes with base offset + 84.
- R8: A format code not accepted for the selected generation raises `fmt_err_o` with `err_vec_o` = 14, `sp_delta_o` = 0 and `sr_we_o` low.
- R9: On generation 0 the format code is ignored: every code finishes with `sp_delta_o` equal to the base offset.
- R10: `sr_we_o` is high exactly in the cycles where `done_o` is high. In those cycles `sr_o` equals the `sr_i` value that was present with the matching start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to decode the fetched frame |
| format_i | input | 4 | Frame format code from the format/vector word |
| base_off_i | input | OFF_W | Stack bytes already consumed by status, PC and format word |
| gen_i | input | 2 | Generation select (0 base, 1 second, 2 third/fourth, 3 fifth) |
| mmu_var_i | input | 1 | Memory-management variant of the third/fourth generation |
| sr_i | input | SR_W | Status word read from the frame |
| done_o | output | 1 | Frame accepted; the instruction completes |
| reread_o | output | 1 | Throwaway frame popped; the next frame must be decoded |
| fmt_err_o | output | 1 | Frame rejected; a format-error trap is raised |
| err_vec_o | output | 8 | Trap vector number, 14 with a format error, otherwise 0 |
| sp_delta_o | output | OFF_W+1 | Bytes to add to the stack pointer |
| sr_we_o | output | 1 | Commit the restored status word |
| sr_o | output | SR_W | Status word to commit |

## Verification
The assertions assume that `start_i` is never high in the cycle `rst_n` is released and that `gen_i`, `format_i`, `base_off_i` and `sr_i` are valid whenever `start_i` is high. Nothing is assumed about their values at other times. The stimulus changes inputs only on the falling clock edge and holds start high for one cycle at a time. It keeps the base offset within its declared width, including its maximum value. It sweeps all sixteen format codes on every generation, with the variant flag both low and high.

// File: rtl/rte_pkg.sv
package rte_pkg;

    typedef enum logic [1:0] {
        GEN_BASE   = 2'd0,
        GEN_SECOND = 2'd1,
        GEN_THIRD  = 2'd2,
        GEN_FIFTH  = 2'd3
    } gen_e;

    typedef enum logic [1:0] {
        RES_NONE   = 2'd0,
        RES_DONE   = 2'd1,
        RES_REREAD = 2'd2,
        RES_ERROR  = 2'd3
    } res_e;

    // widest extra discard is 84 bytes
    localparam int EXTRA_W = 7;

endpackage

// File: rtl/rte_fmt_table.sv
module rte_fmt_table
    import rte_pkg::*;
#(
    parameter bit ALLOW_MMU_FRAME = 1'b1
) (
    input  gen_e               gen_i,
    input  logic               mmu_var_i,
    input  logic [3:0]         format_i,
    output logic               legal_o,
    output logic               throwaway_o,
    output logic [EXTRA_W-1:0] extra_o
);

    logic mmu_ok;

    generate
        if (ALLOW_MMU_FRAME) begin : g_mmu
            assign mmu_ok = mmu_var_i;
        end else begin : g_no_mmu
            assign mmu_ok = 1'b0;
        end
    endgenerate

    logic               ok;
    logic [EXTRA_W-1:0] bytes;

    always_comb begin
        ok          = 1'b0;
        bytes       = '0;
        throwaway_o = 1'b0;
        case (format_i)
            4'h0: ok = 1'b1;
            4'h1: begin
                ok          = (gen_i == GEN_THIRD) || (gen_i == GEN_FIFTH);
                throwaway_o = ok;
            end
            4'h2: begin
                ok    = (gen_i == GEN_THIRD) || (gen_i == GEN_FIFTH);
                bytes = EXTRA_W'(4);
            end
            4'h3: begin
                ok    = (gen_i == GEN_FIFTH);
                bytes = EXTRA_W'(4);
            end
            4'h4: begin
                ok    = (gen_i == GEN_FIFTH);
                bytes = EXTRA_W'(8);
            end
            4'h7: begin
                ok    = (gen_i == GEN_FIFTH);
                bytes = EXTRA_W'(52);
            end
            4'h8: begin
                ok    = (gen_i == GEN_SECOND);
                bytes = EXTRA_W'(50);
            end
            4'h9: begin
                ok    = (gen_i == GEN_THIRD);
                bytes = EXTRA_W'(12);
            end
            4'hB: begin
                ok    = (gen_i == GEN_THIRD) && mmu_ok;
                bytes = EXTRA_W'(84);
            end
            default: ok = 1'b0;
        endcase
        legal_o = ok;
        extra_o = ok ? bytes : '0;
    end

endmodule

// File: rtl/rte_delta_calc.sv
module rte_delta_calc
    import rte_pkg::*;
#(
    parameter int OFF_W = 8
) (
    input  res_e               kind_i,
    input  logic [OFF_W-1:0]   base_i,
    input  logic [EXTRA_W-1:0] extra_i,
    output logic [OFF_W:0]     delta_o
);

    localparam int DW = OFF_W + 1;

    always_comb begin
        case (kind_i)
            RES_DONE:   delta_o = DW'(base_i) + DW'(extra_i);
            RES_REREAD: delta_o = DW'(base_i);
            default:    delta_o = '0;
        endcase
    end

endmodule

// File: rtl/rte_frame_decoder.sv
module rte_frame_decoder
    import rte_pkg::*;
#(
    parameter int OFF_W           = 8,
    parameter int SR_W            = 16,
    parameter int ERR_VECTOR      = 14,
    parameter bit ALLOW_MMU_FRAME = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [3:0]       format_i,
    input  logic [OFF_W-1:0] base_off_i,
    input  logic [1:0]       gen_i,
    input  logic             mmu_var_i,
    input  logic [SR_W-1:0]  sr_i,
    output logic             done_o,
    output logic             reread_o,
    output logic             fmt_err_o,
    output logic [7:0]       err_vec_o,
    output logic [OFF_W:0]   sp_delta_o,
    output logic             sr_we_o,
    output logic [SR_W-1:0]  sr_o
);

    typedef struct packed {
        res_e             kind;
        logic [OFF_W:0]   delta;
        logic [SR_W-1:0]  sr;
    } state_t;

    state_t st_d, st_q;

    gen_e               gen;
    logic               legal;
    logic               throwaway;
    logic [EXTRA_W-1:0] extra;
    res_e               kind_d;
    logic [OFF_W:0]     delta_d;

    assign gen = gen_e'(gen_i);

    rte_fmt_table #(
        .ALLOW_MMU_FRAME (ALLOW_MMU_FRAME)
    ) u_table (
        .gen_i       (gen),
        .mmu_var_i   (mmu_var_i),
        .format_i    (format_i),
        .legal_o     (legal),
        .throwaway_o (throwaway),
        .extra_o     (extra)
    );

    always_comb begin
        kind_d = RES_NONE;
        if (start_i) begin
            if (gen == GEN_BASE)  kind_d = RES_DONE;
            else if (!legal)      kind_d = RES_ERROR;
            else if (throwaway)   kind_d = RES_REREAD;
            else                  kind_d = RES_DONE;
        end
    end

    rte_delta_calc #(
        .OFF_W (OFF_W)
    ) u_delta (
        .kind_i  (kind_d),
        .base_i  (base_off_i),
        .extra_i ((gen == GEN_BASE) ? '0 : extra),
        .delta_o (delta_d)
    );

    always_comb begin
        st_d       = st_q;
        st_d.kind  = kind_d;
        st_d.delta = delta_d;
        if (start_i) begin
            st_d.sr = sr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{kind: RES_NONE, delta: '0, sr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o     = (st_q.kind == RES_DONE);
    assign reread_o   = (st_q.kind == RES_REREAD);
    assign fmt_err_o  = (st_q.kind == RES_ERROR);
    assign err_vec_o  = fmt_err_o ? 8'(ERR_VECTOR) : 8'd0;
    assign sp_delta_o = st_q.delta;
    assign sr_we_o    = done_o;
    assign sr_o       = st_q.sr;

endmodule

// File: rtl/rte_frame_decoder_chk.sv
module rte_frame_decoder_chk #(
    parameter int OFF_W = 8,
    parameter int SR_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [3:0]       format_i,
    input logic [OFF_W-1:0] base_off_i,
    input logic [1:0]       gen_i,
    input logic             mmu_var_i,
    input logic [SR_W-1:0]  sr_i,
    input logic             done_o,
    input logic             reread_o,
    input logic             fmt_err_o,
    input logic [7:0]       err_vec_o,
    input logic [OFF_W:0]   sp_delta_o,
    input logic             sr_we_o,
    input logic [SR_W-1:0]  sr_o
);

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> $countones({done_o, reread_o, fmt_err_o}) == 1);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o && !reread_o && !fmt_err_o && sp_delta_o == '0);

    // R3
    fmt0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && format_i == 4'h0 |=> done_o && sp_delta_o == (OFF_W+1)'($past(base_off_i)));

    // R5
    throwaway_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && format_i == 4'h1 && gen_i[1] |=> reread_o && sp_delta_o == (OFF_W+1)'($past(base_off_i)));

    // R8
    err_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err_o |-> sp_delta_o == '0 && !sr_we_o && err_vec_o == 8'd14);

    // R9
    base_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && gen_i == 2'd0 |=> done_o && sp_delta_o == (OFF_W+1)'($past(base_off_i)));

    // R10
    commit_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we_o == done_o);

    // R10
    sr_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> sr_o == $past(sr_i));

endmodule

bind rte_frame_decoder rte_frame_decoder_chk #(.OFF_W(OFF_W), .SR_W(SR_W)) u_chk (.*);

// File: tb/rte_frame_decoder_tb.sv
`timescale 1ns/1ps
module rte_frame_decoder_tb;

    localparam int OFF_W = 8;
    localparam int SR_W  = 16;

    // kind codes used by the bench: 0 none, 1 done, 2 reread, 3 error
    typedef struct packed {
        logic [1:0]       gen;
        logic             mmu;
        logic [3:0]       fmt;
        logic [OFF_W-1:0] base;
        logic [1:0]       kind;
        logic [OFF_W:0]   delta;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 4'h0, 8'd8,   2'd1, 9'd8},   // R3
        '{2'd3, 1'b0, 4'h0, 8'd6,   2'd1, 9'd6},   // R3
        '{2'd1, 1'b0, 4'h8, 8'd8,   2'd1, 9'd58},  // R4
        '{2'd2, 1'b0, 4'h8, 8'd8,   2'd3, 9'd0},   // R4 R8
        '{2'd2, 1'b0, 4'h2, 8'd8,   2'd1, 9'd12},  // R5
        '{2'd2, 1'b0, 4'h1, 8'd8,   2'd2, 9'd8},   // R5
        '{2'd1, 1'b0, 4'h1, 8'd8,   2'd3, 9'd0},   // R5 R8
        '{2'd3, 1'b0, 4'h3, 8'd8,   2'd1, 9'd12},  // R6
        '{2'd3, 1'b0, 4'h4, 8'd8,   2'd1, 9'd16},  // R6
        '{2'd3, 1'b0, 4'h7, 8'd8,   2'd1, 9'd60},  // R6
        '{2'd2, 1'b0, 4'h7, 8'd8,   2'd3, 9'd0},   // R6 R8
        '{2'd2, 1'b0, 4'h9, 8'd8,   2'd1, 9'd20},  // R7
        '{2'd3, 1'b0, 4'h9, 8'd8,   2'd3, 9'd0},   // R7 R8
        '{2'd2, 1'b1, 4'hB, 8'd8,   2'd1, 9'd92},  // R7
        '{2'd2, 1'b0, 4'hB, 8'd8,   2'd3, 9'd0},   // R7 R8
        '{2'd0, 1'b0, 4'hF, 8'd6,   2'd1, 9'd6},   // R9
        '{2'd3, 1'b0, 4'hF, 8'd255, 2'd3, 9'd0},   // R8
        '{2'd3, 1'b0, 4'h7, 8'd255, 2'd1, 9'd307}  // R6 widest sum
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [3:0]       format_i = '0;
    logic [OFF_W-1:0] base_off_i = '0;
    logic [1:0]       gen_i = '0;
    logic             mmu_var_i = 1'b0;
    logic [SR_W-1:0]  sr_i = '0;
    logic             done_o, reread_o, fmt_err_o, sr_we_o;
    logic [7:0]       err_vec_o;
    logic [OFF_W:0]   sp_delta_o;
    logic [SR_W-1:0]  sr_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rte_frame_decoder #(.OFF_W(OFF_W), .SR_W(SR_W)) u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference outcome built from the requirements
    function automatic void ref_model(input int gen, input bit mmu, input int fmt, input int base,
                                      output int kind, output int delta);
        int extra;
        bit ok;
        bit thr;
        ok = 0; thr = 0; extra = 0;
        if (gen == 0) begin
            ok = 1;
        end else begin
            case (fmt)
                0:  ok = 1;
                1:  begin ok = (gen >= 2); thr = 1; end
                2:  begin ok = (gen >= 2); extra = 4; end
                3:  begin ok = (gen == 3); extra = 4; end
                4:  begin ok = (gen == 3); extra = 8; end
                7:  begin ok = (gen == 3); extra = 52; end
                8:  begin ok = (gen == 1); extra = 50; end
                9:  begin ok = (gen == 2); extra = 12; end
                11: begin ok = (gen == 2) && mmu; extra = 84; end
                default: ok = 0;
            endcase
        end
        if (!ok)      begin kind = 3; delta = 0; end
        else if (thr) begin kind = 2; delta = base; end
        else          begin kind = 1; delta = base + extra; end
    endfunction

    task automatic apply(input int gen, input bit mmu, input int fmt, input int base, input int sr);
        @(negedge clk);
        start_i    = 1'b1;
        gen_i      = 2'(gen);
        mmu_var_i  = mmu;
        format_i   = 4'(fmt);
        base_off_i = OFF_W'(base);
        sr_i       = SR_W'(sr);
        @(negedge clk);
        start_i    = 1'b0;
        format_i   = 4'hE;
        sr_i       = '1;
    endtask

    task automatic check_result(input string tag, input int kind, input int delta, input int sr);
        chk({tag, " R2 done"},   int'(done_o),    int'(kind == 1));
        chk({tag, " R5 reread"}, int'(reread_o),  int'(kind == 2));
        chk({tag, " R8 error"},  int'(fmt_err_o), int'(kind == 3));
        chk({tag, " delta"},     int'(sp_delta_o), delta);
        chk({tag, " R8 vector"}, int'(err_vec_o), (kind == 3) ? 14 : 0);
        chk({tag, " R10 sr_we"}, int'(sr_we_o),   int'(kind == 1));
        if (kind == 1) chk({tag, " R10 sr"}, int'(sr_o), sr);
    endtask

    initial begin
        int k, d;
        // R1 during reset
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", int'({done_o, reread_o, fmt_err_o, sr_we_o}), 0);
        chk("R1 reset delta", int'(sp_delta_o), 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'({done_o, reread_o, fmt_err_o, sr_we_o, err_vec_o}), 0);
        chk("R1 delta after release", int'(sp_delta_o), 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            apply(int'(VECS[i].gen), VECS[i].mmu, int'(VECS[i].fmt), int'(VECS[i].base), 16'h2700 + i);
            check_result($sformatf("table %0d", i), int'(VECS[i].kind), int'(VECS[i].delta), 16'h2700 + i);
        end

        // R2 idle after a result
        @(negedge clk);
        chk("R2 idle", int'({done_o, reread_o, fmt_err_o}), 0);
        chk("R2 idle delta", int'(sp_delta_o), 0);

        // full sweep: R3 R4 R5 R6 R7 R8 R9
        for (int g = 0; g < 4; g++) begin
            for (int m = 0; m < 2; m++) begin
                for (int f = 0; f < 16; f++) begin
                    ref_model(g, m[0], f, 10 + f, k, d);
                    apply(g, m[0], f, 10 + f, 16'h0100 * f + g);
                    check_result($sformatf("sweep g%0d m%0d f%0d", g, m, f), k, d, 16'h0100 * f + g);
                end
            end
        end

        // back-to-back starts: R2 R10
        @(negedge clk);
        start_i = 1'b1; gen_i = 2'd3; mmu_var_i = 1'b0; format_i = 4'h4; base_off_i = 8'd8; sr_i = 16'hA5A5;
        @(negedge clk);
        check_result("b2b first", 1, 16, 16'hA5A5);
        format_i = 4'h5; sr_i = 16'h5A5A;
        @(negedge clk);
        start_i = 1'b0;
        check_result("b2b second", 3, 0, 0);
        chk("R10 sr held on error", int'(sr_o), 16'h5A5A);

        // reset in the middle of a result: R1
        apply(2, 1'b0, 2, 8, 16'h1234);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset", int'({done_o, reread_o, fmt_err_o, sr_we_o}), 0);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule